// File: doc/BRIEF.md
# Regulator Start-up Sequencer and Protection Latch

This block sits in the digital part of a two-phase step-down regulator controller. It decides when the power stage may switch. It produces the digital set-point that feeds the reference converter, and it latches protective shutdowns. It watches two supply-good flags, an inhibit request, a 5-bit voltage-select code and two comparator flags (output too high, output too low). It is paced by a one-cycle tick issued once per switching period.

Once both supplies are good, start-up proceeds in stages. While it waits for the ramp, the block holds the low-side switches on to drain the output. The set-point then climbs from zero to the selected target in 2048 switching periods, with an exact-division accumulator. High-side switching is released when the set-point reaches the carrier valley level. Under-voltage checking starts at a lower level, and power-good checking starts only when the climb is complete. An over-voltage, a persistent under-voltage or the reserved all-ones select code each lead to their own latched state. Only the asynchronous reset clears a latched state; that reset stands in for cycling the supply.

Top module: `startupGuard`

## Requirements
- R1: The ramp starts only when vccGood and drvGood are both 1, inhibit is 0 and vid is not 5'b11111. Until then refMv stays 0 and highEn and pgEn stay 0, whatever ticks arrive.
- R2: Before the ramp, lowEn equals drvGood. During the ramp and afterwards, lowEn is 1.
- R3: The target in millivolts is 1850 - 25*vid for vid 0..30, so 0 gives 1850 and 30 gives 1100. It is sampled when the ramp starts, and later vid changes other than to 31 do not alter it.
- R4: After k ticks of the ramp, refMv = floor(target*k/2048). On the 2048th tick it equals the target, and it holds that value from then on.
- R5: During the ramp, highEn is 1 exactly when refMv >= 1000. After the ramp completes, highEn is 1.
- R6: uvEn is 1 once refMv >= 800 during the ramp. pgEn becomes 1 only in the cycle after the 2048th tick's edge and not before.
- R7: If uvFlag is high at two consecutive ticks while uvEn is 1 (and stays high between them), fault rises and lowEn, highEn and pgEn drop, and this is latched. A high uvFlag at a single tick has no effect.
- R8: If ovFlag is high in any cycle during or after the ramp, then from the next edge onwards fault=1, lowEn=1 and highEn=0, latched. Later inhibit or flag changes do not alter this.
- R9: vid = 5'b11111 outside a latched state turns lowEn, highEn and pgEn off, with fault=0. This is latched, and a later vid change does not restart the block.
- R10: inhibit=1 turns lowEn, highEn and pgEn off and clears refMv to 0. Releasing it restarts the ramp from zero.
- R11: If either supply flag drops during or after the ramp, the block returns to waiting: refMv=0, highEn=0, pgEn=0 and lowEn=drvGood.
- R12: The asynchronous reset rstN=0 puts the block in the waiting state and clears any latched condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset (models a supply cycle) |
| tick | input | 1 | One-cycle pulse per switching period |
| vccGood | input | 1 | Controller supply above its turn-on level |
| drvGood | input | 1 | Driver supply above its turn-on level |
| inhibit | input | 1 | Request to stop all switching |
| vid | input | 5 | Voltage-select code |
| ovFlag | input | 1 | Output over-voltage comparator flag |
| uvFlag | input | 1 | Output under-voltage comparator flag |
| refMv | output | 16 | Set-point code in millivolts |
| lowEn | output | 1 | Low-side switches enabled / held on |
| highEn | output | 1 | High-side switching enabled |
| uvEn | output | 1 | Under-voltage check armed |
| pgEn | output | 1 | Power-good check enabled |
| fault | output | 1 | Latched protection fault |

## Verification
Each tick changes refMv at the same clock edge that samples the tick, because the set-point is the top of a registered accumulator. The bench therefore samples on the falling edge after each tick pulse. State-driven outputs (highEn, pgEn, fault) change one edge after the condition is presented. The 2048th tick moves the block into the complete state at that same edge, so pgEn is checked right after that edge and also one tick earlier. Inputs that act through the state (inhibit, supply loss, over-voltage) are applied on a falling edge and checked one or two falling edges later. The under-voltage persistence is checked after the first and after the second qualifying tick.

// File: rtl/startupGuardPkg.sv
package startupGuardPkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_RAMP,
    ST_DONE,
    ST_HOLD,
    ST_OVLATCH,
    ST_UVLATCH,
    ST_NOLOAD
  } guardState_e;

  typedef struct packed {
    logic clear;   // zero accumulator and tick count
    logic load;    // capture target from select code
    logic step;    // advance one ramp tick
  } rampCmd_t;

endpackage

// File: rtl/startupGuardPath.sv
module startupGuardPath
  import startupGuardPkg::*;
#(
  parameter int REF_W     = 16,
  parameter int VID_W     = 5,
  parameter int RAMP_LOG2 = 11,
  parameter int BASE_MV   = 1850,
  parameter int STEP_MV   = 25,
  parameter int HS_MV     = 1000,
  parameter int UV_MV     = 800
) (
  input  logic             clk,
  input  logic             rstN,
  input  rampCmd_t         cmd,
  input  logic [VID_W-1:0] vid,
  output logic [REF_W-1:0] refMv,
  output logic             rampLast,
  output logic             refAtHs,
  output logic             refAtUv
);
  localparam int ACC_W      = REF_W + RAMP_LOG2;
  localparam int CNT_W      = RAMP_LOG2 + 1;
  localparam int RAMP_TICKS = 1 << RAMP_LOG2;

  logic [REF_W-1:0] target;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] vidMv;

  assign vidMv = REF_W'(BASE_MV - STEP_MV * int'(vid));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target <= '0;
      acc    <= '0;
      cnt    <= '0;
    end else begin
      if (cmd.load) target <= vidMv;
      if (cmd.clear) begin
        acc <= '0;
        cnt <= '0;
      end else if (cmd.step) begin
        acc <= acc + ACC_W'(target);
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign refMv    = acc[ACC_W-1:RAMP_LOG2];
  assign rampLast = (cnt == CNT_W'(RAMP_TICKS - 1));
  assign refAtHs  = (refMv >= REF_W'(HS_MV));
  assign refAtUv  = (refMv >= REF_W'(UV_MV));

endmodule

// File: rtl/startupGuardCtrl.sv
module startupGuardCtrl
  import startupGuardPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  logic     vccGood,
  input  logic     drvGood,
  input  logic     inhibit,
  input  logic     vidAllOnes,
  input  logic     ovFlag,
  input  logic     uvFlag,
  input  logic     rampLast,
  input  logic     refAtHs,
  input  logic     refAtUv,
  output rampCmd_t cmd,
  output logic     lowEn,
  output logic     highEn,
  output logic     uvEn,
  output logic     pgEn,
  output logic     fault
);
  guardState_e state, stateNext;
  logic uvSeen, uvSeenNext, uvArm, uvTrip, suppliesOk, active, activeNext;

  assign suppliesOk = vccGood && drvGood;
  assign active     = (state == ST_RAMP) || (state == ST_DONE);
  assign uvArm      = ((state == ST_RAMP) && refAtUv) || (state == ST_DONE);
  assign uvTrip     = tick && uvFlag && uvArm && uvSeen;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WAIT: begin
        if (vidAllOnes)      stateNext = ST_NOLOAD;
        else if (inhibit)    stateNext = ST_HOLD;
        else if (suppliesOk) stateNext = ST_RAMP;
      end
      ST_RAMP, ST_DONE: begin
        if (ovFlag)           stateNext = ST_OVLATCH;
        else if (uvTrip)      stateNext = ST_UVLATCH;
        else if (vidAllOnes)  stateNext = ST_NOLOAD;
        else if (inhibit)     stateNext = ST_HOLD;
        else if (!suppliesOk) stateNext = ST_WAIT;
        else if ((state == ST_RAMP) && tick && rampLast) stateNext = ST_DONE;
      end
      ST_HOLD: if (!inhibit) stateNext = ST_WAIT;
      default: stateNext = state;
    endcase
  end

  assign activeNext = (stateNext == ST_RAMP) || (stateNext == ST_DONE);

  always_comb begin
    cmd.clear = !activeNext;
    cmd.load  = (state == ST_WAIT);
    cmd.step  = (state == ST_RAMP) && tick && activeNext;
  end

  always_comb begin
    uvSeenNext = uvSeen;
    if (!uvFlag || !uvArm) uvSeenNext = 1'b0;
    else if (tick)         uvSeenNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_WAIT;
      uvSeen <= 1'b0;
    end else begin
      state  <= stateNext;
      uvSeen <= uvSeenNext;
    end
  end

  always_comb begin
    lowEn  = 1'b0;
    highEn = 1'b0;
    uvEn   = 1'b0;
    pgEn   = 1'b0;
    fault  = 1'b0;
    unique case (state)
      ST_WAIT:    lowEn = drvGood;
      ST_RAMP: begin
        lowEn  = 1'b1;
        highEn = refAtHs;
        uvEn   = uvArm;
      end
      ST_DONE: begin
        lowEn  = 1'b1;
        highEn = 1'b1;
        uvEn   = 1'b1;
        pgEn   = 1'b1;
      end
      ST_OVLATCH: begin
        lowEn = 1'b1;
        fault = 1'b1;
      end
      ST_UVLATCH: fault = 1'b1;
      default: ;
    endcase
  end

  logic unusedActive;
  assign unusedActive = active;

endmodule

// File: rtl/startupGuard.sv
module startupGuard
  import startupGuardPkg::*;
#(
  parameter int REF_W     = 16,
  parameter int VID_W     = 5,
  parameter int RAMP_LOG2 = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             vccGood,
  input  logic             drvGood,
  input  logic             inhibit,
  input  logic [VID_W-1:0] vid,
  input  logic             ovFlag,
  input  logic             uvFlag,
  output logic [REF_W-1:0] refMv,
  output logic             lowEn,
  output logic             highEn,
  output logic             uvEn,
  output logic             pgEn,
  output logic             fault
);
  rampCmd_t cmd;
  logic rampLast, refAtHs, refAtUv;

  startupGuardPath #(
    .REF_W(REF_W), .VID_W(VID_W), .RAMP_LOG2(RAMP_LOG2)
  ) path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .vid(vid),
    .refMv(refMv), .rampLast(rampLast), .refAtHs(refAtHs), .refAtUv(refAtUv)
  );

  startupGuardCtrl ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .vccGood(vccGood), .drvGood(drvGood), .inhibit(inhibit),
    .vidAllOnes(&vid), .ovFlag(ovFlag), .uvFlag(uvFlag),
    .rampLast(rampLast), .refAtHs(refAtHs), .refAtUv(refAtUv),
    .cmd(cmd), .lowEn(lowEn), .highEn(highEn), .uvEn(uvEn),
    .pgEn(pgEn), .fault(fault)
  );

endmodule

// File: rtl/startupGuardChk.sv
module startupGuardChk #(
  parameter int REF_W = 16,
  parameter int VID_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             inhibit,
  input logic [VID_W-1:0] vid,
  input logic             ovFlag,
  input logic [REF_W-1:0] refMv,
  input logic             lowEn,
  input logic             highEn,
  input logic             uvEn,
  input logic             pgEn,
  input logic             fault
);
  AST_HIGH_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    highEn |-> lowEn);  // R5

  AST_PG_IMPLIES_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    pgEn |-> (highEn && uvEn && !fault));  // R6

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);  // R7

  AST_OV_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (ovFlag && highEn) |=> (fault && lowEn && !highEn));  // R8

  AST_NOLOAD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ((&vid) && !fault && !ovFlag) |=> (!lowEn && !highEn && !pgEn));  // R9

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit && $past(inhibit) && $past(rstN) && !fault)
      |-> (!lowEn && !highEn && refMv == '0));  // R10

  AST_REF_RISES: assert property (@(posedge clk) disable iff (!rstN)
    ((refMv != $past(refMv)) && (refMv != '0)) |-> (refMv > $past(refMv)));  // R4

endmodule

bind startupGuard startupGuardChk #(.REF_W(REF_W), .VID_W(VID_W)) chk (
  .clk(clk), .rstN(rstN), .inhibit(inhibit), .vid(vid), .ovFlag(ovFlag),
  .refMv(refMv), .lowEn(lowEn), .highEn(highEn), .uvEn(uvEn),
  .pgEn(pgEn), .fault(fault)
);

// File: tb/startupGuard_test.sv
module startupGuard_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, vccGood = 1'b0, drvGood = 1'b0, inhibit = 1'b0;
  logic [4:0] vid = 5'd0;
  logic ovFlag = 1'b0, uvFlag = 1'b0;
  logic [15:0] refMv;
  logic lowEn, highEn, uvEn, pgEn, fault;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  startupGuard uut (
    .clk(clk), .rstN(rstN), .tick(tick), .vccGood(vccGood), .drvGood(drvGood),
    .inhibit(inhibit), .vid(vid), .ovFlag(ovFlag), .uvFlag(uvFlag),
    .refMv(refMv), .lowEn(lowEn), .highEn(highEn), .uvEn(uvEn),
    .pgEn(pgEn), .fault(fault)
  );

  localparam int VEC_N = 7;
  // vid, ticks applied
  localparam int VECS [VEC_N][2] = '{
    '{0, 2048}, '{30, 2048}, '{10, 1024}, '{0, 1107},
    '{0, 1108}, '{20, 1}, '{20, 2047}
  };

  function automatic int tgtOf(int v);
    return 1850 - 25 * v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic doReset(logic vg, logic dg, logic [4:0] v);
    @(negedge clk);
    rstN = 1'b0; tick = 1'b0; inhibit = 1'b0; ovFlag = 1'b0; uvFlag = 1'b0;
    vccGood = vg; drvGood = dg; vid = v;
    cyc(2);
    rstN = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R12: reset state
    doReset(1'b0, 1'b0, 5'd0);
    rstN = 1'b0;
    cyc(1);
    chk("R12 ref in reset", refMv, 0);
    chk("R12 outputs in reset", {lowEn, highEn, uvEn, pgEn, fault}, 0);
    rstN = 1'b1;

    // vector table: R3, R4, R5, R6
    for (int i = 0; i < VEC_N; i++) begin
      int v = VECS[i][0];
      int k = VECS[i][1];
      int er = tgtOf(v) * k / 2048;
      doReset(1'b1, 1'b1, 5'(v));
      cyc(2);
      ticks(k);
      chk("R4 ref after ticks", refMv, er);
      chk("R5 highEn", highEn, (k >= 2048) ? 1 : int'(er >= 1000));
      chk("R6 uvEn", uvEn, int'(er >= 800));
      chk("R6 pgEn", pgEn, int'(k >= 2048));
      chk("R2 lowEn in ramp", lowEn, 1);
    end

    // R1: controller supply missing, driver ok: no ramp, pre-discharge on
    doReset(1'b0, 1'b1, 5'd0);
    cyc(2);
    ticks(20);
    chk("R1 no ramp without vccGood", refMv, 0);
    chk("R2 lowEn equals drvGood while waiting", lowEn, 1);
    chk("R1 highEn off while waiting", highEn, 0);
    // R1: driver supply missing
    doReset(1'b1, 1'b0, 5'd0);
    cyc(2);
    ticks(20);
    chk("R1 no ramp without drvGood", refMv, 0);
    chk("R2 lowEn off without drvGood", lowEn, 0);

    // R3: target sampled at ramp start
    doReset(1'b1, 1'b1, 5'd10);
    cyc(2);
    ticks(100);
    vid = 5'd0;
    ticks(1948);
    chk("R3 target held after vid change", refMv, 1600);
    chk("R4 held after completion", refMv, 1600);
    ticks(5);
    chk("R4 ref stays at target", refMv, 1600);

    // R11: supply loss after completion, then restart from zero
    doReset(1'b1, 1'b1, 5'd30);
    cyc(2);
    ticks(2048);
    @(negedge clk) vccGood = 1'b0;
    @(negedge clk);
    chk("R11 ref cleared on supply loss", refMv, 0);
    chk("R11 pgEn off on supply loss", pgEn, 0);
    chk("R11 lowEn follows drvGood", lowEn, 1);
    chk("R11 highEn off", highEn, 0);
    vccGood = 1'b1;
    cyc(2);
    ticks(2);
    chk("R11 ramp restarts from zero", refMv, 1100 * 2 / 2048);

    // R10: inhibit during completion, release restarts ramp
    doReset(1'b1, 1'b1, 5'd0);
    cyc(2);
    ticks(2048);
    @(negedge clk) inhibit = 1'b1;
    cyc(2);
    chk("R10 lowEn off in inhibit", lowEn, 0);
    chk("R10 highEn/pgEn off in inhibit", {highEn, pgEn}, 0);
    chk("R10 ref cleared in inhibit", refMv, 0);
    inhibit = 1'b0;
    cyc(3);
    ticks(1024);
    chk("R10 ramp restarted from zero", refMv, 1850 * 1024 / 2048);
    chk("R10 highEn below carrier valley", highEn, 0);

    // R7: under-voltage ignored below 0.8 V level
    doReset(1'b1, 1'b1, 5'd0);
    cyc(2);
    uvFlag = 1'b1;
    ticks(100);
    chk("R7 uv ignored before armed", fault, 0);
    uvFlag = 1'b0;
    ticks(1948);
    // single qualifying tick: no effect
    @(negedge clk) uvFlag = 1'b1;
    ticks(1);
    chk("R7 single uv tick no fault", fault, 0);
    uvFlag = 1'b0;
    cyc(1);
    uvFlag = 1'b1;
    ticks(1);
    chk("R7 flag dropped between ticks no fault", fault, 0);
    ticks(1);
    chk("R7 two consecutive uv ticks fault", fault, 1);
    chk("R7 switches off on uv", {lowEn, highEn, pgEn}, 0);
    uvFlag = 1'b0;
    inhibit = 1'b1;
    cyc(3);
    inhibit = 1'b0;
    cyc(3);
    chk("R7 uv fault latched", fault, 1);

    // R12: reset clears latched fault
    doReset(1'b1, 1'b1, 5'd0);
    cyc(2);
    ticks(4);
    chk("R12 reset clears fault", fault, 0);
    chk("R12 ramp after reset", refMv, 1850 * 4 / 2048);

    // R8: over-voltage during ramp
    doReset(1'b1, 1'b1, 5'd0);
    cyc(2);
    ticks(50);
    @(negedge clk) ovFlag = 1'b1;
    @(negedge clk) ovFlag = 1'b0;
    chk("R8 ov fault set", fault, 1);
    chk("R8 low on high off", {lowEn, highEn}, 2'b10);
    inhibit = 1'b1;
    cyc(3);
    inhibit = 1'b0;
    ticks(10);
    chk("R8 ov latched through inhibit", {fault, lowEn, highEn}, 3'b110);

    // R9: all-ones select code
    doReset(1'b1, 1'b1, 5'd0);
    cyc(2);
    ticks(1200);
    @(negedge clk) vid = 5'h1f;
    @(negedge clk);
    chk("R9 all off on no-load code", {lowEn, highEn, pgEn}, 0);
    chk("R9 fault stays low", fault, 0);
    vid = 5'd5;
    cyc(3);
    ticks(10);
    chk("R9 latched after vid change", {lowEn, highEn, pgEn}, 0);
    chk("R9 ref stays zero", refMv, 0);

    finish();
  end
endmodule